// File: doc/BRIEF.md
# Display Command Stream Decoder

This block sits behind a byte-wide valid/ready stream that carries framed commands for a display controller. Each command opens with the prefix byte 0xAF. The block knows two commands. The first is a single-register write. Its payload goes into a shadow register file and, subject to a lock state, into the active register file that drives the display timing logic. The second is a short memory-copy request. Its source address, pixel count and destination address are put together and handed to a copy engine as a one-cycle strobe with its fields. The copy itself is done elsewhere.

Timing updates can be made atomic with a lock/unlock pair on a dedicated register address. While the block is locked, writes only reach the shadow copies. The unlock write moves every shadow value into the active file in a single clock. The active file is brought out flat, together with three decoded views: the colour-depth selection and the two framebuffer base pointers. If the stream holds an unknown opcode or a stray byte, the decoder sets a sticky error flag. It then drops bytes until the next prefix byte.

Top module: `dispcmd_decoder`

## Requirements
- R1: After reset every shadow and active register reads 0x00, `locked` and `errFlag` are low, `copyValid` is low, and `depthIs16` is high.
- R2: While unlocked, the command 0xAF, 0x20, addr, data (addr below NUM_REGS) updates active register addr, and the new value shows on `activeRegs[addr*8 +: 8]` in the cycle after the data byte is accepted.
- R3: The command 0xAF, 0x20, 0xFF, 0x00 sets `locked`. While locked, register writes leave `activeRegs` unchanged.
- R4: The command 0xAF, 0x20, 0xFF, 0xFF clears `locked` and copies every shadow register into the active file in the same clock, so all staged writes appear together.
- R5: A write to address 0xFF with any data value other than 0x00 or 0xFF changes neither `locked` nor any register.
- R6: `fb16Base` is {reg 0x20, reg 0x21, reg 0x22}, with the most significant byte at 0x20. `fb8Base` is built the same way from 0x26..0x28. `depthIs16` is high exactly when active register 0x00 is 0.
- R7: The copy command 0xAF, 0x6A, s2, s1, s0, n, d2, d1, d0 produces a single-cycle `copyValid` in the cycle after d0 is accepted, with `copySrc`={s2,s1,s0}, `copyCount`=n and `copyDst`={d2,d1,d0}. The fields change only together with the strobe.
- R8: A lone 0xAF followed by another 0xAF, or left at the end of the stream, has no effect: no error and no register change.
- R9: An opcode other than 0x20, 0x6A or 0xAF sets the sticky `errFlag`. Bytes are discarded up to the next 0xAF, and the command that follows decodes normally.
- R10: A byte other than 0xAF arriving where a prefix is expected sets `errFlag`, and the decoder resynchronises on the next 0xAF.
- R11: Register writes to addresses from NUM_REGS to 0xFE are dropped and change no register.
- R12: `inReady` is always high. Cycles with `inValid` low change no decoder state, whatever `inData` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | 8 | Stream byte |
| inValid | input | 1 | Stream byte valid |
| inReady | output | 1 | Decoder accepts a byte (always high) |
| activeRegs | output | NUM_REGS*8 | Active register file, register i at bits i*8 +: 8 |
| locked | output | 1 | Register updates are staged |
| depthIs16 | output | 1 | Colour-depth register selects 16 bits per pixel |
| fb16Base | output | 24 | 16bpp framebuffer base address |
| fb8Base | output | 24 | 8bpp framebuffer base address |
| errFlag | output | 1 | Sticky framing error |
| copyValid | output | 1 | One-cycle copy request strobe |
| copySrc | output | 24 | Copy source address |
| copyCount | output | 8 | Copy pixel count |
| copyDst | output | 24 | Copy destination address |

## Verification
The hardest case to reach is a long run of staged writes mixed with lock, unlock, ignored lock-register values and copy commands. In that case the active file must stay frozen until one unlock publishes everything at once, and the copy fields must still be taken apart correctly between register traffic. Seeded random command sequences produce this mix, with idle gaps that carry junk data (including 0xAF) on a deasserted valid. The error and resync paths need a fresh reset so that the sticky flag can be observed for each cause, and directed sequences cover them.

// File: rtl/dispcmd_pkg.sv
package dispcmd_pkg;

  localparam logic [7:0] PREFIX_BYTE = 8'hAF;
  localparam logic [7:0] OP_REGWR    = 8'h20;
  localparam logic [7:0] OP_COPY     = 8'h6A;
  localparam logic [7:0] LOCK_ADDR   = 8'hFF;
  localparam logic [7:0] LOCK_VAL    = 8'h00;
  localparam logic [7:0] UNLOCK_VAL  = 8'hFF;
  localparam int         DEPTH_REG   = 8'h00;
  localparam int         BASE16_REG  = 8'h20;
  localparam int         BASE8_REG   = 8'h26;

  typedef enum logic [2:0] {
    ST_PREFIX,
    ST_OPCODE,
    ST_RADDR,
    ST_RDATA,
    ST_SRC,
    ST_COUNT,
    ST_DST,
    ST_SKIP
  } decState_t;

  typedef struct packed {
    logic capAddr;
    logic wrReg;
    logic shiftAddr;
    logic latchSrc;
    logic latchCnt;
    logic fireCopy;
    logic setErr;
  } decStrobe_t;

endpackage

// File: rtl/dispcmd_ctrl.sv
module dispcmd_ctrl
  import dispcmd_pkg::*;
#(
  parameter int ADDR_BYTES = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       take,
  input  logic [7:0] inData,
  output decStrobe_t strb,
  output logic       errFlag
);

  localparam int CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);

  decState_t stQ, stNext;
  logic [CNT_W-1:0] idxQ, idxNext;
  logic errQ;

  always_comb begin
    stNext  = stQ;
    idxNext = idxQ;
    strb    = '0;
    if (take) begin
      unique case (stQ)
        ST_PREFIX: begin
          if (inData == PREFIX_BYTE) begin
            stNext = ST_OPCODE;
          end else begin
            strb.setErr = 1'b1;
            stNext = ST_SKIP;
          end
        end
        ST_SKIP: begin
          if (inData == PREFIX_BYTE) stNext = ST_OPCODE;
        end
        ST_OPCODE: begin
          if (inData == OP_REGWR) begin
            stNext = ST_RADDR;
          end else if (inData == OP_COPY) begin
            stNext  = ST_SRC;
            idxNext = '0;
          end else if (inData == PREFIX_BYTE) begin
            stNext = ST_OPCODE;
          end else begin
            strb.setErr = 1'b1;
            stNext = ST_SKIP;
          end
        end
        ST_RADDR: begin
          strb.capAddr = 1'b1;
          stNext = ST_RDATA;
        end
        ST_RDATA: begin
          strb.wrReg = 1'b1;
          stNext = ST_PREFIX;
        end
        ST_SRC: begin
          strb.shiftAddr = 1'b1;
          if (idxQ == LAST_IDX) begin
            strb.latchSrc = 1'b1;
            idxNext = '0;
            stNext = ST_COUNT;
          end else begin
            idxNext = idxQ + 1'b1;
          end
        end
        ST_COUNT: begin
          strb.latchCnt = 1'b1;
          idxNext = '0;
          stNext = ST_DST;
        end
        ST_DST: begin
          strb.shiftAddr = 1'b1;
          if (idxQ == LAST_IDX) begin
            strb.fireCopy = 1'b1;
            idxNext = '0;
            stNext = ST_PREFIX;
          end else begin
            idxNext = idxQ + 1'b1;
          end
        end
        default: stNext = ST_SKIP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ  <= ST_PREFIX;
      idxQ <= '0;
      errQ <= 1'b0;
    end else begin
      stQ  <= stNext;
      idxQ <= idxNext;
      if (strb.setErr) errQ <= 1'b1;
    end
  end

  assign errFlag = errQ;

endmodule

// File: rtl/dispcmd_datapath.sv
module dispcmd_datapath
  import dispcmd_pkg::*;
#(
  parameter int NUM_REGS   = 48,
  parameter int ADDR_BYTES = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [7:0]              inData,
  input  decStrobe_t              strb,
  output logic [NUM_REGS*8-1:0]   activeFlat,
  output logic                    locked,
  output logic                    copyValid,
  output logic [ADDR_BYTES*8-1:0] copySrc,
  output logic [7:0]              copyCount,
  output logic [ADDR_BYTES*8-1:0] copyDst
);

  localparam int AW = ADDR_BYTES * 8;

  logic [7:0]    regAddrQ;
  logic          lockQ;
  logic [AW-1:0] asmQ;
  logic [AW-1:0] srcHoldQ;
  logic [7:0]    cntHoldQ;
  logic [AW-1:0] asmNext;

  logic hitLockReg;
  logic doLock;
  logic doPublish;

  assign hitLockReg = strb.wrReg && (regAddrQ == LOCK_ADDR);
  assign doLock     = hitLockReg && (inData == LOCK_VAL);
  assign doPublish  = hitLockReg && (inData == UNLOCK_VAL);
  assign asmNext    = {asmQ[AW-9:0], inData};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regAddrQ <= '0;
      lockQ    <= 1'b0;
    end else begin
      if (strb.capAddr) regAddrQ <= inData;
      if (doLock) lockQ <= 1'b1;
      else if (doPublish) lockQ <= 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [7:0] shadowQ;
    logic [7:0] activeQ;
    logic       wrHit;

    assign wrHit = strb.wrReg && (regAddrQ == 8'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        shadowQ <= '0;
        activeQ <= '0;
      end else begin
        if (wrHit) shadowQ <= inData;
        if (doPublish) activeQ <= shadowQ;
        else if (wrHit && !lockQ) activeQ <= inData;
      end
    end

    assign activeFlat[i*8 +: 8] = activeQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      asmQ      <= '0;
      srcHoldQ  <= '0;
      cntHoldQ  <= '0;
      copyValid <= 1'b0;
      copySrc   <= '0;
      copyCount <= '0;
      copyDst   <= '0;
    end else begin
      if (strb.shiftAddr) asmQ <= asmNext;
      if (strb.latchSrc) srcHoldQ <= asmNext;
      if (strb.latchCnt) cntHoldQ <= inData;
      copyValid <= strb.fireCopy;
      if (strb.fireCopy) begin
        copySrc   <= srcHoldQ;
        copyCount <= cntHoldQ;
        copyDst   <= asmNext;
      end
    end
  end

  assign locked = lockQ;

endmodule

// File: rtl/dispcmd_decoder.sv
module dispcmd_decoder
  import dispcmd_pkg::*;
#(
  parameter int NUM_REGS   = 48,
  parameter int ADDR_BYTES = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [7:0]              inData,
  input  logic                    inValid,
  output logic                    inReady,
  output logic [NUM_REGS*8-1:0]   activeRegs,
  output logic                    locked,
  output logic                    depthIs16,
  output logic [23:0]             fb16Base,
  output logic [23:0]             fb8Base,
  output logic                    errFlag,
  output logic                    copyValid,
  output logic [ADDR_BYTES*8-1:0] copySrc,
  output logic [7:0]              copyCount,
  output logic [ADDR_BYTES*8-1:0] copyDst
);

  decStrobe_t strb;
  logic take;

  assign inReady = 1'b1;
  assign take    = inValid && inReady;

  dispcmd_ctrl #(.ADDR_BYTES(ADDR_BYTES)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .take   (take),
    .inData (inData),
    .strb   (strb),
    .errFlag(errFlag)
  );

  dispcmd_datapath #(.NUM_REGS(NUM_REGS), .ADDR_BYTES(ADDR_BYTES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .inData    (inData),
    .strb      (strb),
    .activeFlat(activeRegs),
    .locked    (locked),
    .copyValid (copyValid),
    .copySrc   (copySrc),
    .copyCount (copyCount),
    .copyDst   (copyDst)
  );

  assign depthIs16 = (activeRegs[DEPTH_REG*8 +: 8] == 8'h00);
  assign fb16Base  = {activeRegs[BASE16_REG*8 +: 8],
                      activeRegs[(BASE16_REG+1)*8 +: 8],
                      activeRegs[(BASE16_REG+2)*8 +: 8]};
  assign fb8Base   = {activeRegs[BASE8_REG*8 +: 8],
                      activeRegs[(BASE8_REG+1)*8 +: 8],
                      activeRegs[(BASE8_REG+2)*8 +: 8]};

endmodule

// File: rtl/dispcmd_decoder_checker.sv
module dispcmd_decoder_checker #(
  parameter int NUM_REGS   = 48,
  parameter int ADDR_BYTES = 3
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [7:0]              inData,
  input logic                    inValid,
  input logic                    inReady,
  input logic [NUM_REGS*8-1:0]   activeRegs,
  input logic                    locked,
  input logic                    errFlag,
  input logic                    copyValid,
  input logic [ADDR_BYTES*8-1:0] copyDst
);

  AST_FROZEN_WHILE_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> (!locked || $stable(activeRegs))); // R3

  AST_LOCK_FROM_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(inValid && inReady && inData == 8'h00)); // R3

  AST_UNLOCK_FROM_FF_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> $past(inValid && inReady && inData == 8'hFF)); // R4

  AST_COPY_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    copyValid |=> !copyValid); // R7

  AST_COPY_FIELD_WITH_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(copyDst) |-> copyValid); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag); // R9

  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && inReady) |=> ($stable(activeRegs) && $stable(locked))); // R12

endmodule

bind dispcmd_decoder dispcmd_decoder_checker #(.NUM_REGS(NUM_REGS), .ADDR_BYTES(ADDR_BYTES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inData    (inData),
  .inValid   (inValid),
  .inReady   (inReady),
  .activeRegs(activeRegs),
  .locked    (locked),
  .errFlag   (errFlag),
  .copyValid (copyValid),
  .copyDst   (copyDst)
);

// File: tb/dispcmd_decoder_test.sv
`timescale 1ns/1ps
module dispcmd_decoder_test;

  localparam int NREG = 48;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] inData = '0;
  logic inValid = 1'b0;
  logic inReady;
  logic [NREG*8-1:0] activeRegs;
  logic locked, depthIs16, errFlag, copyValid;
  logic [23:0] fb16Base, fb8Base, copySrc, copyDst;
  logic [7:0] copyCount;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] expShadow [NREG];
  logic [7:0] expActive [NREG];
  logic expLocked;
  logic expErr;

  always #10 clk = ~clk;

  dispcmd_decoder #(.NUM_REGS(NREG), .ADDR_BYTES(3)) uut (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid), .inReady(inReady),
    .activeRegs(activeRegs), .locked(locked), .depthIs16(depthIs16),
    .fb16Base(fb16Base), .fb8Base(fb8Base), .errFlag(errFlag),
    .copyValid(copyValid), .copySrc(copySrc), .copyCount(copyCount), .copyDst(copyDst)
  );

  function automatic logic [NREG*8-1:0] expFlat();
    logic [NREG*8-1:0] f;
    for (int i = 0; i < NREG; i++) f[i*8 +: 8] = expActive[i];
    return f;
  endfunction

  function automatic logic [23:0] expBase(int a);
    return {expActive[a], expActive[a+1], expActive[a+2]};
  endfunction

  task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b, input bit gaps);
    if (gaps) begin
      repeat ($urandom_range(0, 2)) begin
        inValid = 1'b0;
        inData = 8'($urandom);
        @(negedge clk);
      end
    end
    inValid = 1'b1;
    inData = b;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    inValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < NREG; i++) begin
      expShadow[i] = 8'h00;
      expActive[i] = 8'h00;
    end
    expLocked = 1'b0;
    expErr = 1'b0;
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [7:0] d, input bit gaps);
    put(8'hAF, gaps); put(8'h20, gaps); put(a, gaps); put(d, gaps);
    if (a == 8'hFF) begin
      if (d == 8'h00) expLocked = 1'b1;
      else if (d == 8'hFF) begin
        expLocked = 1'b0;
        for (int i = 0; i < NREG; i++) expActive[i] = expShadow[i];
      end
    end else if (int'(a) < NREG) begin
      expShadow[a] = d;
      if (!expLocked) expActive[a] = d;
    end
  endtask

  task automatic copyCmd(input logic [23:0] s, input logic [7:0] n, input logic [23:0] d, input bit gaps);
    put(8'hAF, gaps); put(8'h6A, gaps);
    put(s[23:16], gaps); put(s[15:8], gaps); put(s[7:0], gaps);
    put(n, gaps);
    put(d[23:16], gaps); put(d[15:8], gaps); put(d[7:0], gaps);
    chk("R7 copyValid", 512'(copyValid), 512'(1'b1));
    chk("R7 copySrc", 512'(copySrc), 512'(s));
    chk("R7 copyCount", 512'(copyCount), 512'(n));
    chk("R7 copyDst", 512'(copyDst), 512'(d));
  endtask

  task automatic chkState(input string tag);
    chk({tag, " activeRegs"}, 512'(activeRegs), 512'(expFlat()));
    chk({tag, " locked"}, 512'(locked), 512'(expLocked));
    chk({tag, " errFlag"}, 512'(errFlag), 512'(expErr));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    doReset();
    @(negedge clk);
    // R1 reset state
    chkState("R1");
    chk("R1 copyValid", 512'(copyValid), 512'(1'b0));
    chk("R1 depthIs16", 512'(depthIs16), 512'(1'b1));

    // R2 direct write while unlocked
    regWrite(8'h05, 8'h5A, 1'b0);
    chkState("R2");

    // R6 base pointers and depth
    regWrite(8'h20, 8'h12, 1'b0); regWrite(8'h21, 8'h34, 1'b0); regWrite(8'h22, 8'h56, 1'b0);
    regWrite(8'h26, 8'hAB, 1'b0); regWrite(8'h27, 8'hCD, 1'b0); regWrite(8'h28, 8'hEF, 1'b0);
    chk("R6 fb16Base", 512'(fb16Base), 512'(24'h123456));
    chk("R6 fb8Base", 512'(fb8Base), 512'(24'hABCDEF));
    regWrite(8'h00, 8'h01, 1'b0);
    chk("R6 depthIs16 off", 512'(depthIs16), 512'(1'b0));

    // R3 lock, staged writes invisible
    regWrite(8'hFF, 8'h00, 1'b0);
    chkState("R3 lock");
    regWrite(8'h00, 8'h00, 1'b0);
    regWrite(8'h20, 8'h99, 1'b0);
    regWrite(8'h2F, 8'h77, 1'b0);
    chkState("R3 staged");
    chk("R3 fb16Base held", 512'(fb16Base), 512'(24'h123456));

    // R5 odd value to lock register
    regWrite(8'hFF, 8'h3C, 1'b0);
    chkState("R5");

    // R4 unlock publishes all at once
    regWrite(8'hFF, 8'hFF, 1'b0);
    chkState("R4");
    chk("R4 fb16Base", 512'(fb16Base), 512'(24'h993456));
    chk("R4 depthIs16", 512'(depthIs16), 512'(1'b1));

    // R11 out-of-range address dropped
    regWrite(8'(NREG), 8'hEE, 1'b0);
    regWrite(8'hFE, 8'hEE, 1'b0);
    chkState("R11");

    // R7 copy, strobe one cycle
    copyCmd(24'h010203, 8'h40, 24'hA0B0C0, 1'b0);
    @(negedge clk);
    chk("R7 pulse width", 512'(copyValid), 512'(1'b0));
    chk("R7 field hold", 512'(copyDst), 512'(24'hA0B0C0));

    // R12 idle cycles with junk data
    inValid = 1'b0;
    inData = 8'hAF; @(negedge clk);
    inData = 8'h20; @(negedge clk);
    inData = 8'h03; @(negedge clk);
    inData = 8'h44; @(negedge clk);
    chkState("R12");
    regWrite(8'h03, 8'h66, 1'b1);
    chkState("R12 gaps");

    // R8 lone prefix padding
    put(8'hAF, 1'b0);
    regWrite(8'h04, 8'h21, 1'b0);
    chkState("R8 double prefix");
    put(8'hAF, 1'b0);
    repeat (3) @(negedge clk);
    chkState("R8 trailing prefix");

    // R9 unknown opcode
    put(8'h55, 1'b0);
    put(8'h20, 1'b0); put(8'h07, 1'b0); put(8'h99, 1'b0);
    expErr = 1'b1;
    chkState("R9 discard");
    regWrite(8'h07, 8'h31, 1'b0);
    chkState("R9 recover");

    // R10 stray byte where prefix expected
    doReset();
    @(negedge clk);
    put(8'h33, 1'b0); put(8'h20, 1'b0); put(8'h01, 1'b0);
    expErr = 1'b1;
    chkState("R10 stray");
    regWrite(8'h01, 8'hC3, 1'b0);
    chkState("R10 resync");

    // seeded random mix
    doReset();
    @(negedge clk);
    for (int n = 0; n < 300; n++) begin
      int sel;
      sel = $urandom_range(0, 9);
      case (sel)
        0: regWrite(8'hFF, 8'h00, 1'b1);
        1: regWrite(8'hFF, 8'hFF, 1'b1);
        2: regWrite(8'hFF, 8'($urandom_range(1, 254)), 1'b1);
        3: copyCmd(24'($urandom), 8'($urandom), 24'($urandom), 1'b1);
        default: regWrite(8'($urandom_range(0, NREG + 7)), 8'($urandom), 1'b1);
      endcase
      chkState("R2 R3 R4 R5 random");
    end
    chk("R6 random fb16Base", 512'(fb16Base), 512'(expBase(8'h20)));
    chk("R6 random fb8Base", 512'(fb8Base), 512'(expBase(8'h26)));

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule